// File: doc/BRIEF.md
# Mixed-Width Dual-Clock RAM

This block is a 4608-bit synchronous memory with one write port and one read port. Each port has its own clock and its own synchronous active-low reset, and the two clocks need not be related. Each port picks its own shape at run time through a 3-bit shape code: 4096 x 1, 2048 x 2, 1024 x 4, 512 x 9 or 256 x 18. A word written at one shape can be read back at any other shape, so the block also acts as a bus-width converter.

Storage is 512 lanes of 9 bits, split into an even-lane bank and an odd-lane bank so that an 18-bit access reaches two lanes in one cycle. The narrow shapes (1, 2 and 4 bits) use only bits [7:0] of a lane. They never write bit 8 and never return it. The read port can add one extra output register stage, chosen by a mode input.

Top module: `mrw_ram`

## Requirements
- R1: While `rd_rst_n` is low at a rising `rd_clk` edge, `rd_data` reads all zeros after that edge.
- R2: Shape codes are 0 = 1 bit, 1 = 2 bits, 2 = 4 bits, 3 = 9 bits and 4 = 18 bits. Codes 5, 6 and 7 behave exactly like code 0.
- R3: An 18-bit access at address A uses only A[7:0]. It maps lane 2A to data bits [8:0] and lane 2A+1 to data bits [17:9].
- R4: A narrow access of width w in {1,2,4} at address A selects lane A/(8/w) and bit field starting at (A mod (8/w))*w, with lower sub-indices at lower bits. Write data comes from bits [w-1:0]; read data is zero-extended to 18 bits. A 9-bit access maps A[8:0] to one whole lane, zero-extended on read.
- R5: Narrow writes leave bit 8 of the lane unchanged, and narrow reads never return it.
- R6: Data written at any shape reads back at any shape according to the lane mapping of R3 and R4.
- R7: With `rd_pipe` = 0, `rd_data` shows the addressed data after the `rd_clk` edge that samples `rd_en` high. With `rd_pipe` = 1, it shows the data one `rd_clk` edge later.
- R8: While `rd_en` is low, `rd_data` holds its last value, even when the address or the shape code changes.
- R9: A write-clock edge with `wr_en` low changes no stored data.
- R10: The write clock and the read clock run at unrelated frequencies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-port clock |
| wr_rst_n | input | 1 | Synchronous active-low reset, write domain |
| wr_en | input | 1 | Write enable, active high |
| wr_shape | input | 3 | Write shape code |
| wr_addr | input | 12 | Write address, in units of the write shape |
| wr_data | input | 18 | Write data, low bits used for narrow shapes |
| rd_clk | input | 1 | Read-port clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, read domain |
| rd_en | input | 1 | Read enable, active high |
| rd_shape | input | 3 | Read shape code |
| rd_addr | input | 12 | Read address, in units of the read shape |
| rd_pipe | input | 1 | 1 adds the output register stage |
| rd_data | output | 18 | Read data, zero-extended for shapes under 18 bits |

## Verification
The hardest case to reach from the ports is a narrow write that lands in a lane whose ninth bit is already set, followed by a wide read of that lane. Only that sequence shows whether bit 8 survived. The bench sets bit 8 with a 9-bit write and then overwrites both nibbles of the same lane. It reads the lane back at 9 bits and at 4 bits. Full sweeps write the whole array at each shape and read it back at a different shape, alternating the latency mode. A reference lane array with the same arithmetic mapping supplies every expected word.

// File: rtl/mrw_pkg.sv
`timescale 1ns/1ps
// mrw_pkg: shared constants, shape codes and address-to-lane mapping for
// the mixed-width RAM. Assumes 9-bit lanes, with an 18-bit word spanning an
// even/odd lane pair.
package mrw_pkg;
    localparam int LANE_W    = 9;
    localparam int LANES     = 512;
    localparam int DATA_W    = 2 * LANE_W;
    localparam int CODE_W    = 3;
    localparam int LANE_IX_W = $clog2(LANES);
    localparam int IDX_W     = LANE_IX_W - 1;
    localparam int ADDR_W    = LANE_IX_W + 3;
    localparam int BANKS     = 2;
    localparam int BANK_D    = LANES / BANKS;

    localparam logic [CODE_W-1:0] SHP_X1  = 3'd0;
    localparam logic [CODE_W-1:0] SHP_X2  = 3'd1;
    localparam logic [CODE_W-1:0] SHP_X4  = 3'd2;
    localparam logic [CODE_W-1:0] SHP_X9  = 3'd3;
    localparam logic [CODE_W-1:0] SHP_X18 = 3'd4;

    typedef struct packed {
        logic [IDX_W-1:0] idx;   // row inside each bank
        logic             sel;   // bank holding the lane (narrow and 9-bit)
        logic [2:0]       ofs;   // bit offset inside the lane (narrow)
    } loc_t;

    // Fold reserved codes onto the 1-bit shape.
    function automatic logic [CODE_W-1:0] canon(input logic [CODE_W-1:0] c);
        return (c > SHP_X18) ? SHP_X1 : c;
    endfunction

    function automatic logic is_narrow(input logic [CODE_W-1:0] c);
        return canon(c) <= SHP_X4;
    endfunction

    function automatic int unsigned shape_bits(input logic [CODE_W-1:0] c);
        case (canon(c))
            SHP_X2:  return 2;
            SHP_X4:  return 4;
            SHP_X9:  return 9;
            SHP_X18: return 18;
            default: return 1;
        endcase
    endfunction

    // Map a shape code and an address to a bank row, a bank and a bit offset.
    function automatic loc_t locate(input logic [CODE_W-1:0] c,
                                    input logic [ADDR_W-1:0] a);
        loc_t                   l;
        logic [LANE_IX_W-1:0]   lane;
        l    = '0;
        lane = '0;
        case (canon(c))
            SHP_X18: l.idx = a[IDX_W-1:0];
            SHP_X9:  lane  = a[LANE_IX_W-1:0];
            SHP_X4: begin
                lane  = a[LANE_IX_W:1];
                l.ofs = {a[0], 2'b00};
            end
            SHP_X2: begin
                lane  = a[LANE_IX_W+1:2];
                l.ofs = {a[1:0], 1'b0};
            end
            default: begin
                lane  = a[LANE_IX_W+2:3];
                l.ofs = a[2:0];
            end
        endcase
        if (canon(c) != SHP_X18) begin
            l.idx = lane[LANE_IX_W-1:1];
            l.sel = lane[0];
        end
        return l;
    endfunction
endpackage

// File: rtl/mrw_wr_map.sv
`timescale 1ns/1ps
// mrw_wr_map: turns a write shape, address and data into a bank row and
// per-bank bit masks and data. Purely combinational. Assumes the caller
// gates the masks with the write enable.
module mrw_wr_map
    import mrw_pkg::*;
(
    input  logic [CODE_W-1:0]            shape,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            data,
    output logic [IDX_W-1:0]             idx,
    output logic [BANKS-1:0][LANE_W-1:0] mask,
    output logic [BANKS-1:0][LANE_W-1:0] dat
);
    loc_t                loc;
    logic [CODE_W-1:0]   c;
    logic [LANE_W-2:0]   m8;
    logic [LANE_W-2:0]   d8;

    // Build the lane masks and the replicated data for the selected shape.
    always_comb begin
        c    = canon(shape);
        loc  = locate(shape, addr);
        idx  = loc.idx;
        mask = '0;
        dat  = '0;
        m8   = '0;
        d8   = '0;
        case (c)
            SHP_X18: begin
                mask[0] = '1;
                mask[1] = '1;
                dat[0]  = data[LANE_W-1:0];
                dat[1]  = data[DATA_W-1:LANE_W];
            end
            SHP_X9: begin
                mask[loc.sel] = '1;
                dat[0]        = data[LANE_W-1:0];
                dat[1]        = data[LANE_W-1:0];
            end
            default: begin
                if (c == SHP_X4) begin
                    m8 = 8'h0F << loc.ofs;
                    d8 = {2{data[3:0]}};
                end else if (c == SHP_X2) begin
                    m8 = 8'h03 << loc.ofs;
                    d8 = {4{data[1:0]}};
                end else begin
                    m8 = 8'h01 << loc.ofs;
                    d8 = {8{data[0]}};
                end
                mask[loc.sel] = {1'b0, m8};
                dat[0]        = {1'b0, d8};
                dat[1]        = {1'b0, d8};
            end
        endcase
    end
endmodule

// File: rtl/mrw_bank.sv
`timescale 1ns/1ps
// mrw_bank: one bank of lanes with a bit-masked write port and a registered
// read port in separate clock domains. Storage is not reset. A read and a
// write of one row on the same edge return the old row.
module mrw_bank #(
    parameter int DEPTH = 256,
    parameter int W     = 9,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [W-1:0]  wmask,
    input  logic [W-1:0]  wdat,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          re,
    input  logic [IW-1:0] ridx,
    output logic [W-1:0]  rq
);
    logic [W-1:0] mem [DEPTH];

    // Write the masked bits of the addressed row.
    always_ff @(posedge wclk) begin
        if (we) begin
            for (int b = 0; b < W; b++) begin
                if (wmask[b]) mem[widx][b] <= wdat[b];
            end
        end
    end

    // Capture the addressed row on an enabled read edge, and hold it otherwise.
    always_ff @(posedge rclk) begin
        if (!rrst_n)  rq <= '0;
        else if (re)  rq <= mem[ridx];
    end
endmodule

// File: rtl/mrw_rd_sel.sv
`timescale 1ns/1ps
// mrw_rd_sel: picks the read word out of the two captured bank rows, using
// the shape, bank and offset registered with them. Combinational. Narrow
// and 9-bit results are zero-extended, and bit 8 is dropped for narrow shapes.
module mrw_rd_sel
    import mrw_pkg::*;
(
    input  logic [CODE_W-1:0]            shape,
    input  logic                         sel,
    input  logic [2:0]                   ofs,
    input  logic [BANKS-1:0][LANE_W-1:0] q,
    output logic [DATA_W-1:0]            word
);
    logic [LANE_W-1:0] lane;
    logic [LANE_W-2:0] sh;

    // Shift the chosen lane's low byte down and trim it to the shape.
    always_comb begin
        lane = q[sel];
        sh   = lane[LANE_W-2:0] >> ofs;
        case (canon(shape))
            SHP_X18: word = {q[1], q[0]};
            SHP_X9:  word = {{(DATA_W-LANE_W){1'b0}}, lane};
            SHP_X4:  word = {{(DATA_W-4){1'b0}}, sh[3:0]};
            SHP_X2:  word = {{(DATA_W-2){1'b0}}, sh[1:0]};
            default: word = {{(DATA_W-1){1'b0}}, sh[0]};
        endcase
    end
endmodule

// File: rtl/mrw_ram.sv
`timescale 1ns/1ps
// mrw_ram: dual-clock RAM whose ports each select a shape of 1, 2, 4, 9 or
// 18 bits at run time, built on two banks of 9-bit lanes. Assumes rd_pipe
// only changes while no read is in flight. Collisions across the two clock
// domains give undefined data.
module mrw_ram
    import mrw_pkg::*;
(
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_shape,
    input  logic [11:0]       wr_addr,
    input  logic [17:0]       wr_data,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    input  logic [2:0]        rd_shape,
    input  logic [11:0]       rd_addr,
    input  logic              rd_pipe,
    output logic [17:0]       rd_data
);
    logic [IDX_W-1:0]             w_idx;
    logic [BANKS-1:0][LANE_W-1:0] w_mask;
    logic [BANKS-1:0][LANE_W-1:0] w_dat;
    logic [BANKS-1:0][LANE_W-1:0] r_q;
    loc_t                         r_loc;
    logic [CODE_W-1:0]            shape_q;
    logic                         sel_q;
    logic [2:0]                   ofs_q;
    logic                         vld_q;
    logic [DATA_W-1:0]            word;
    logic [DATA_W-1:0]            pipe_q;

    mrw_wr_map u_wr_map (
        .shape (wr_shape),
        .addr  (wr_addr),
        .data  (wr_data),
        .idx   (w_idx),
        .mask  (w_mask),
        .dat   (w_dat)
    );

    // Read-side location of the requested word.
    always_comb r_loc = locate(rd_shape, rd_addr);

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        mrw_bank #(.DEPTH(BANK_D), .W(LANE_W)) u_bank (
            .wclk   (wr_clk),
            .we     (wr_en & wr_rst_n),
            .widx   (w_idx),
            .wmask  (w_mask[g]),
            .wdat   (w_dat[g]),
            .rclk   (rd_clk),
            .rrst_n (rd_rst_n),
            .re     (rd_en),
            .ridx   (r_loc.idx),
            .rq     (r_q[g])
        );
    end

    // Keep the selection fields aligned with the captured bank rows.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            shape_q <= SHP_X1;
            sel_q   <= 1'b0;
            ofs_q   <= '0;
        end else if (rd_en) begin
            shape_q <= rd_shape;
            sel_q   <= r_loc.sel;
            ofs_q   <= r_loc.ofs;
        end
    end

    mrw_rd_sel u_rd_sel (
        .shape (shape_q),
        .sel   (sel_q),
        .ofs   (ofs_q),
        .q     (r_q),
        .word  (word)
    );

    // Optional output stage, loaded one edge after an enabled read.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            vld_q  <= 1'b0;
            pipe_q <= '0;
        end else begin
            vld_q <= rd_en;
            if (vld_q) pipe_q <= word;
        end
    end

    assign rd_data = rd_pipe ? pipe_q : word;

    assert_reset_clears_R1: assert property (@(posedge rd_clk)
        !rd_rst_n |=> (rd_data == '0));

    assert_mask_width_R2: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_en |-> ($countones(w_mask) == shape_bits(wr_shape)));

    assert_ninth_bit_kept_R5: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && is_narrow(wr_shape)) |-> (!w_mask[0][LANE_W-1] && !w_mask[1][LANE_W-1]));

    assert_idle_holds_R8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (!rd_en && !$past(rd_en)) |=> ($stable(rd_pipe) -> $stable(rd_data)));
endmodule

// File: tb/mrw_ram_bench.sv
`timescale 1ns/1ps
// Bench for mrw_ram: whole-array sweeps across shapes, checked against a
// reference lane array.
module mrw_ram_bench;
    logic        wr_clk = 0, rd_clk = 0;
    logic        wr_rst_n = 0, rd_rst_n = 0;
    logic        wr_en = 0, rd_en = 0, rd_pipe = 0;
    logic [2:0]  wr_shape = 0, rd_shape = 0;
    logic [11:0] wr_addr = 0, rd_addr = 0;
    logic [17:0] wr_data = 0;
    logic [17:0] rd_data;

    int errors = 0, checks = 0;
    bit done = 0;
    logic [8:0] refm [512];

    always #10 wr_clk = ~wr_clk;   // 50 MHz
    always #13 rd_clk = ~rd_clk;   // unrelated read clock (R10)

    mrw_ram u_mrw_ram (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_shape(wr_shape),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
        .rd_en(rd_en), .rd_shape(rd_shape), .rd_addr(rd_addr), .rd_pipe(rd_pipe),
        .rd_data(rd_data)
    );

    function automatic int wid(input int c);
        case (c) 1: return 2; 2: return 4; 3: return 9; 4: return 18; default: return 1; endcase
    endfunction

    function automatic int depth(input int c);
        case (wid(c)) 18: return 256; 9: return 512; default: return 4096 / wid(c); endcase
    endfunction

    function automatic logic [17:0] pat(input int a, input int r);
        logic [31:0] h;
        h = a * 32'h9E37 + r * 32'h3C1 ^ (a << 7);
        return h[17:0] ^ h[31:14];
    endfunction

    // Apply a write to the reference lane array.
    function automatic void ref_wr(input int c, input int a, input logic [17:0] d);
        int w, per, aa, lane, f;
        w = wid(c);
        if (w == 18) begin
            aa = a % 256;
            refm[2*aa] = d[8:0];
            refm[2*aa+1] = d[17:9];
        end else if (w == 9) begin
            refm[a % 512] = d[8:0];
        end else begin
            per = 8 / w; aa = a % (512 * per);
            lane = aa / per; f = (aa % per) * w;
            for (int b = 0; b < w; b++) refm[lane][f+b] = d[b];
        end
    endfunction

    function automatic logic [17:0] ref_rd(input int c, input int a);
        int w, per, aa, lane, f;
        logic [17:0] v;
        w = wid(c); v = '0;
        if (w == 18) begin
            aa = a % 256;
            v = {refm[2*aa+1], refm[2*aa]};
        end else if (w == 9) begin
            v = {9'b0, refm[a % 512]};
        end else begin
            per = 8 / w; aa = a % (512 * per);
            lane = aa / per; f = (aa % per) * w;
            for (int b = 0; b < w; b++) v[b] = refm[lane][f+b];
        end
        return v;
    endfunction

    task automatic chk(input string tag, input logic [17:0] got, input logic [17:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input int c, input int a, input logic [17:0] d, input bit en);
        @(negedge wr_clk);
        wr_en = en; wr_shape = 3'(c); wr_addr = 12'(a); wr_data = d;
        @(posedge wr_clk);
        @(negedge wr_clk);
        wr_en = 0;
        if (en) ref_wr(c, a, d);
    endtask

    // Read one word; the result is sampled after the edge the latency mode implies.
    task automatic rd(input int c, input int a, input bit pipe, output logic [17:0] q);
        @(negedge rd_clk);
        rd_pipe = pipe; rd_en = 1; rd_shape = 3'(c); rd_addr = 12'(a);
        @(posedge rd_clk);
        @(negedge rd_clk);
        rd_en = 0;
        if (pipe) begin
            @(posedge rd_clk);
            @(negedge rd_clk);
        end
        q = rd_data;
    endtask

    task automatic rd_chk(input string tag, input int c, input int a, input bit pipe);
        logic [17:0] q;
        rd(c, a, pipe, q);
        chk(tag, q, ref_rd(c, a));
    endtask

    initial begin
        logic [17:0] q, prev;
        for (int i = 0; i < 512; i++) refm[i] = '0;
        repeat (4) @(negedge rd_clk);
        @(negedge wr_clk);
        // R1: reset state of the read output in both latency modes
        chk("R1 reset nonpipe", rd_data, 18'h0);
        rd_pipe = 1; #1;
        chk("R1 reset pipe", rd_data, 18'h0);
        rd_pipe = 0;
        wr_rst_n = 1;
        @(negedge rd_clk); rd_rst_n = 1;

        // Clear the array so every lane has a known value.
        for (int a = 0; a < 256; a++) wr(4, a, 18'h0, 1);

        // R4: nibble, pair and bit mapping of one 9-bit word
        wr(3, 3, 18'h0AB, 1);
        rd(2, 6, 0, q);  chk("R4 x4 low", q, 18'hB);
        rd(2, 7, 0, q);  chk("R4 x4 high", q, 18'hA);
        rd(1, 12, 0, q); chk("R4 x2 sub0", q, 18'h3);
        rd(1, 15, 1, q); chk("R4 x2 sub3", q, 18'h2);
        rd(0, 24, 0, q); chk("R4 x1 bit0", q, 18'h1);
        rd(0, 26, 1, q); chk("R4 x1 bit2", q, 18'h0);

        // R3: lane pairing of an 18-bit word and unused upper address bits
        wr(4, 261, 18'h2_A5C3, 1);
        rd(3, 10, 0, q); chk("R3 even lane", q, {9'b0, 9'h1C3});
        rd(3, 11, 0, q); chk("R3 odd lane", q, {9'b0, 9'h152});
        rd(4, 5, 1, q);  chk("R3 upper addr ignored", q, 18'h2_A5C3);

        // R5: narrow writes keep bit 8, narrow reads drop it
        wr(3, 5, 18'h1FF, 1);
        wr(2, 10, 18'h0, 1);
        wr(2, 11, 18'h3FFF0, 1);
        rd(3, 5, 0, q);  chk("R5 ninth bit kept", q, 18'h100);
        wr(3, 6, 18'h1FF, 1);
        rd(2, 13, 0, q); chk("R5 ninth bit not read", q, 18'hF);

        // R2: reserved code acts as the 1-bit shape
        wr(6, 100, 18'h1, 1);
        rd(0, 100, 0, q); chk("R2 reserved write", q, 18'h1);
        rd(7, 100, 0, q); chk("R2 reserved read", q, 18'h1);
        rd(5, 101, 1, q); chk("R2 reserved read neighbour", q, ref_rd(0, 101));

        // R9: a disabled write leaves the word unchanged
        wr(3, 40, 18'h155, 1);
        wr(3, 40, 18'h0AA, 0);
        rd(3, 40, 0, q); chk("R9 disabled write", q, 18'h155);

        // R7: latency in each mode
        wr(3, 7, 18'h111, 1);
        wr(3, 8, 18'h0EE, 1);
        rd(3, 7, 0, q); chk("R7 nonpipe one edge", q, 18'h111);
        @(negedge rd_clk);
        rd_pipe = 1; rd_en = 1; rd_shape = 3'd3; rd_addr = 12'd8;
        @(posedge rd_clk); @(negedge rd_clk);
        rd_en = 0;
        chk("R7 pipe old after first edge", rd_data, 18'h111);
        @(posedge rd_clk); @(negedge rd_clk);
        chk("R7 pipe new after second edge", rd_data, 18'h0EE);

        // R8: idle read port holds its output while inputs move
        for (int m = 0; m < 2; m++) begin
            rd(4, 5, m[0], prev);
            rd_shape = 3'd0; rd_addr = 12'd77;
            repeat (3) @(negedge rd_clk);
            chk("R8 hold", rd_data, prev);
        end

        // R6/R10: fill at each shape, read back at other shapes and modes
        for (int wc = 0; wc < 5; wc++) begin
            for (int a = 0; a < depth(wc); a++) wr(wc, a, pat(a, wc), 1);
            for (int a = 0; a < depth((wc + 1) % 5); a++)
                rd_chk("R6/R10 full sweep", (wc + 1) % 5, a, wc[0]);
            for (int k = 2; k < 5; k++) begin
                int rc;
                rc = (wc + k) % 5;
                for (int j = 0; j < 48; j++)
                    rd_chk("R6 spot", rc, (j * 37 + wc) % depth(rc), j[0]);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #3_800_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule